// File: doc/BRIEF.md
# Two-Lane Pre-Adder Multiply-Add with Systolic Alignment

This block computes a signed sum of two products per clock. Each lane takes three operands (`a`, `b`, `c`), can form `a+b` or `a-b` in a pre-adder, and picks its two multiplier operands according to a shared operand-mode code. The mode can use a pre-adder output, a third operand, or a constant from an eight-entry coefficient bank. A per-lane control negates the product, so it can be switched from cycle to cycle to subtract the product from the total instead of adding it.

The two lane results are summed together with a chain input, which lets several instances be cascaded. When the systolic option is on, lane 1 sees one extra input register and lane 0's product passes through a chain stage register. The cascaded total then equals the flat sum, one cycle later. An optional feedback path adds each new total to the previous output unless the load control asks for a fresh start. The whole pipeline has an asynchronous clear and a common clock enable.

Top module: `preadd_mac2`

## Requirements
- R1: With mode code 0 (and for reserved codes, see R5) a lane contributes `a*b`.
- R2: With mode code 1 a lane contributes `(a±b)*K[sel]`. The pre-adder subtracts (`a-b`) when the lane's `psub` is 1. Lane 0's default bank K[0..7] is 3,-5,7,-11,13,-17,19,-128. Lane 1's default bank is -2,4,-6,8,-10,12,-14,127.
- R3: With mode code 2 a lane contributes `(a±b)*c`.
- R4: With mode code 3 a lane contributes `(a±b)*(a±b)`.
- R5: With mode code 4 a lane contributes `a*K[sel]` and the pre-adder is bypassed. Codes 5, 6 and 7 behave as code 0.
- R6: When a lane's `neg` is 1, its product is subtracted from the total instead of added.
- R7: The signed `chain_in` value is added to the total of the two lanes.
- R8: All inputs sampled at one clock edge together form one total. That total appears on `result` after exactly 3 + SYSTOLIC enabled edges (4 by default). Back-to-back inputs give back-to-back results.
- R9: With ACCUM=1, a sample taken with `load` 0 adds its total to the current `result`. A sample taken with `load` 1 replaces `result` with its total.
- R10: `clr` high forces `result` and every pipeline register to zero at once, without waiting for a clock edge.
- R11: While `ce` is 0 no register changes and inputs are ignored. Data already in the pipeline emerges intact once `ce` returns to 1.
- R12: Operands are signed two's complement of W bits and are sign-extended before the pre-adder and before summation. `result` is RW = 2W+2+GUARD bits wide (24 by default). Full-scale values give exact results, e.g. (-128 + -128)^2 = 65536.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| clr | input | 1 | Asynchronous clear, active high |
| ce | input | 1 | Clock enable for all registers |
| mode | input | 3 | Operand-mode code shared by both lanes |
| a0 | input | W | Lane 0 operand a |
| b0 | input | W | Lane 0 operand b |
| c0 | input | W | Lane 0 third operand |
| sel0 | input | 3 | Lane 0 coefficient index |
| psub0 | input | 1 | Lane 0 pre-adder subtract |
| neg0 | input | 1 | Lane 0 product subtract |
| a1 | input | W | Lane 1 operand a |
| b1 | input | W | Lane 1 operand b |
| c1 | input | W | Lane 1 third operand |
| sel1 | input | 3 | Lane 1 coefficient index |
| psub1 | input | 1 | Lane 1 pre-adder subtract |
| neg1 | input | 1 | Lane 1 product subtract |
| chain_in | input | RW | Cascade value added to the total |
| load | input | 1 | 1: replace the accumulator, 0: add to it |
| result | output | RW | Registered result |

## Verification
The properties that look back over the pipeline assume `ce` has been high for the whole latency. A counter in the checker enforces this instead of a long `$past` chain. They also assume that zero operands and a zero chain value produce a zero total in every mode code, including the reserved ones. The stimulus keeps every operand inside W signed bits. It keeps running totals well inside RW bits, so the accumulator never wraps. Every `ce` freeze is followed by enough enabled cycles to drain the pipeline before a value is compared.

// File: rtl/pam_pkg.sv
`timescale 1ns/1ps
package pam_pkg;
    typedef enum logic [2:0] {
        PM_SIMPLE = 3'd0,
        PM_COEF   = 3'd1,
        PM_INPUT  = 3'd2,
        PM_SQUARE = 3'd3,
        PM_CONST  = 3'd4
    } pam_mode_e;
endpackage

// File: rtl/pam_lane.sv
`timescale 1ns/1ps
module pam_lane #(
    parameter int W     = 8,
    parameter int NCOEF = 8,
    parameter int COEF [NCOEF] = '{default: 0},
    parameter int EXTRA = 0,
    localparam int SELW = $clog2(NCOEF),
    localparam int PW   = 2*W + 2
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 ce,
    input  logic [2:0]           mode,
    input  logic signed [W-1:0]  a,
    input  logic signed [W-1:0]  b,
    input  logic signed [W-1:0]  c,
    input  logic [SELW-1:0]      sel,
    input  logic                 psub,
    input  logic                 neg,
    output logic signed [PW-1:0] prod
);
    import pam_pkg::*;

    localparam int D  = 1 + EXTRA;
    localparam int IW = 3 + 3*W + SELW + 2;

    // coefficient bank, fixed at elaboration
    logic signed [W-1:0] bank [NCOEF];
    for (genvar k = 0; k < NCOEF; k++) begin : g_bank
        assign bank[k] = W'(COEF[k]);
    end

    // input register chain (one stage, plus one systolic delay if EXTRA)
    logic [IW-1:0] stg [D];
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            for (int k = 0; k < D; k++) stg[k] <= '0;
        end else if (ce) begin
            stg[0] <= {mode, a, b, c, sel, psub, neg};
            for (int k = 1; k < D; k++) stg[k] <= stg[k-1];
        end
    end

    logic [2:0]          m_r;
    logic signed [W-1:0] a_r, b_r, c_r;
    logic [SELW-1:0]     s_r;
    logic                ps_r, ng_r;
    assign {m_r, a_r, b_r, c_r, s_r, ps_r, ng_r} = stg[D-1];

    // pre-adder and operand selection
    logic signed [W:0]    ax, bx, cx, kx, pre, opx, opy;
    logic signed [PW-1:0] xe, ye, mul;
    always_comb begin
        ax  = {a_r[W-1], a_r};
        bx  = {b_r[W-1], b_r};
        cx  = {c_r[W-1], c_r};
        kx  = {bank[s_r][W-1], bank[s_r]};
        pre = ps_r ? (ax - bx) : (ax + bx);
        unique case (pam_mode_e'(m_r))
            PM_COEF:   begin opx = pre; opy = kx;  end
            PM_INPUT:  begin opx = pre; opy = cx;  end
            PM_SQUARE: begin opx = pre; opy = pre; end
            PM_CONST:  begin opx = ax;  opy = kx;  end
            default:   begin opx = ax;  opy = bx;  end
        endcase
        xe  = PW'(opx);
        ye  = PW'(opy);
        mul = xe * ye;
    end

    // product register with dynamic add/subtract
    always_ff @(posedge clk or posedge clr) begin
        if (clr)     prod <= '0;
        else if (ce) prod <= ng_r ? -mul : mul;
    end
endmodule

// File: rtl/pam_sum.sv
`timescale 1ns/1ps
module pam_sum #(
    parameter int RW       = 24,
    parameter int PW       = 18,
    parameter int SYSTOLIC = 1,
    parameter int ACCUM    = 1
) (
    input  logic                 clk,
    input  logic                 clr,
    input  logic                 ce,
    input  logic signed [PW-1:0] p0,
    input  logic signed [PW-1:0] p1,
    input  logic signed [RW-1:0] chain_in,
    input  logic                 load,
    output logic signed [RW-1:0] acc
);
    localparam int D = 2 + SYSTOLIC;

    logic signed [RW-1:0] x0, x1;
    assign x0 = {{(RW-PW){p0[PW-1]}}, p0};
    assign x1 = {{(RW-PW){p1[PW-1]}}, p1};

    // control and chain travel alongside the operands
    logic [RW:0] cp [D];
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            for (int k = 0; k < D; k++) cp[k] <= '0;
        end else if (ce) begin
            cp[0] <= {load, chain_in};
            for (int k = 1; k < D; k++) cp[k] <= cp[k-1];
        end
    end

    logic                 ld_d;
    logic signed [RW-1:0] ch_d, total;
    assign {ld_d, ch_d} = cp[D-1];

    if (SYSTOLIC != 0) begin : g_sys
        logic signed [RW-1:0] st_q;
        always_ff @(posedge clk or posedge clr) begin
            if (clr)     st_q <= '0;
            else if (ce) st_q <= x0;
        end
        assign total = st_q + x1;
    end else begin : g_flat
        assign total = x0 + x1;
    end

    logic signed [RW-1:0] fb;
    assign fb = (ACCUM != 0 && !ld_d) ? acc : '0;

    always_ff @(posedge clk or posedge clr) begin
        if (clr)     acc <= '0;
        else if (ce) acc <= total + ch_d + fb;
    end
endmodule

// File: rtl/preadd_mac2.sv
`timescale 1ns/1ps
module preadd_mac2 #(
    parameter int W        = 8,
    parameter int GUARD    = 6,
    parameter int NCOEF    = 8,
    parameter int SYSTOLIC = 1,
    parameter int ACCUM    = 1,
    parameter int COEF_L0 [NCOEF] = '{3, -5, 7, -11, 13, -17, 19, -128},
    parameter int COEF_L1 [NCOEF] = '{-2, 4, -6, 8, -10, 12, -14, 127},
    localparam int SELW = $clog2(NCOEF),
    localparam int PW   = 2*W + 2,
    localparam int RW   = PW + GUARD
) (
    input  logic            clk,
    input  logic            clr,
    input  logic            ce,
    input  logic [2:0]      mode,
    input  logic [W-1:0]    a0,
    input  logic [W-1:0]    b0,
    input  logic [W-1:0]    c0,
    input  logic [SELW-1:0] sel0,
    input  logic            psub0,
    input  logic            neg0,
    input  logic [W-1:0]    a1,
    input  logic [W-1:0]    b1,
    input  logic [W-1:0]    c1,
    input  logic [SELW-1:0] sel1,
    input  logic            psub1,
    input  logic            neg1,
    input  logic [RW-1:0]   chain_in,
    input  logic            load,
    output logic [RW-1:0]   result
);
    logic signed [PW-1:0] p0, p1;
    logic signed [RW-1:0] acc;

    pam_lane #(.W(W), .NCOEF(NCOEF), .COEF(COEF_L0), .EXTRA(0)) u_lane0 (
        .clk(clk), .clr(clr), .ce(ce), .mode(mode),
        .a(a0), .b(b0), .c(c0), .sel(sel0), .psub(psub0), .neg(neg0),
        .prod(p0)
    );

    pam_lane #(.W(W), .NCOEF(NCOEF), .COEF(COEF_L1), .EXTRA(SYSTOLIC)) u_lane1 (
        .clk(clk), .clr(clr), .ce(ce), .mode(mode),
        .a(a1), .b(b1), .c(c1), .sel(sel1), .psub(psub1), .neg(neg1),
        .prod(p1)
    );

    pam_sum #(.RW(RW), .PW(PW), .SYSTOLIC(SYSTOLIC), .ACCUM(ACCUM)) u_sum (
        .clk(clk), .clr(clr), .ce(ce), .p0(p0), .p1(p1),
        .chain_in(chain_in), .load(load), .acc(acc)
    );

    assign result = acc;
endmodule

// File: rtl/pam_checker.sv
`timescale 1ns/1ps
module pam_checker #(
    parameter int W        = 8,
    parameter int RW       = 24,
    parameter int SYSTOLIC = 1,
    parameter int ACCUM    = 1
) (
    input logic          clk,
    input logic          clr,
    input logic          ce,
    input logic          load,
    input logic [W-1:0]  a0, b0, c0, a1, b1, c1,
    input logic [RW-1:0] chain_in,
    input logic [RW-1:0] result
);
    localparam int LAT = 3 + SYSTOLIC;

    logic [3:0] ce_run;
    always_ff @(posedge clk or posedge clr) begin
        if (clr)                    ce_run <= '0;
        else if (!ce)               ce_run <= '0;
        else if (ce_run < 4'(LAT))  ce_run <= ce_run + 4'd1;
    end

    logic quiet;
    assign quiet = (a0 == '0) && (b0 == '0) && (c0 == '0) &&
                   (a1 == '0) && (b1 == '0) && (c1 == '0) && (chain_in == '0);

    // R10: clear forces zero output
    always @(posedge clk) begin
        if (clr) assert_clear_zero_R10: assert (result == '0);
    end

    // R11: disabled clock holds the output
    assert_hold_ce_R11: assert property (@(posedge clk) disable iff (clr)
        !ce |=> $stable(result));

    // R8: a zero-operand load sample yields zero exactly LAT edges later
    assert_zero_latency_R8: assert property (@(posedge clk) disable iff (clr)
        (ce_run >= 4'(LAT)) && $past(quiet && load, LAT) |-> (result == '0));

    // R9: a zero-operand accumulate sample leaves the output unchanged
    if (ACCUM != 0) begin : g_acc
        assert_acc_hold_R9: assert property (@(posedge clk) disable iff (clr)
            (ce_run >= 4'(LAT)) && $past(quiet && !load, LAT) |-> (result == $past(result)));
    end
endmodule

bind preadd_mac2 pam_checker #(.W(W), .RW(RW), .SYSTOLIC(SYSTOLIC), .ACCUM(ACCUM)) u_chk (
    .clk(clk), .clr(clr), .ce(ce), .load(load),
    .a0(a0), .b0(b0), .c0(c0), .a1(a1), .b1(b1), .c1(c1),
    .chain_in(chain_in), .result(result)
);

// File: tb/tb_preadd_mac2.sv
`timescale 1ns/1ps
module tb_preadd_mac2;
    localparam int LAT = 4;
    localparam int RW  = 24;

    logic clk = 0, clr = 1, ce = 0, load = 0, psub0, psub1, neg0, neg1;
    logic [2:0] mode, sel0, sel1;
    logic [7:0] a0, b0, c0, a1, b1, c1;
    logic [RW-1:0] chain_in, result;

    always #2 clk = ~clk;

    preadd_mac2 dut (.clk(clk), .clr(clr), .ce(ce), .mode(mode),
        .a0(a0), .b0(b0), .c0(c0), .sel0(sel0), .psub0(psub0), .neg0(neg0),
        .a1(a1), .b1(b1), .c1(c1), .sel1(sel1), .psub1(psub1), .neg1(neg1),
        .chain_in(chain_in), .load(load), .result(result));

    typedef struct packed {
        logic [2:0] m;
        logic signed [7:0] a0, b0, c0; logic [2:0] s0; logic p0, n0;
        logic signed [7:0] a1, b1, c1; logic [2:0] s1; logic p1, n1;
        logic signed [23:0] ch;
        logic [23:0] tag;
    } vec_t;

    localparam int NV = 11;
    localparam vec_t TV [NV] = '{
        '{3'd0,   8'sd5,  -8'sd3, 8'sd0,    3'd0,1'b0,1'b0,  8'sd7,   8'sd2,  8'sd0,  3'd0,1'b0,1'b0, 24'sd0,     "R1"},
        '{3'd1,   8'sd10,  8'sd4, 8'sd0,    3'd2,1'b0,1'b0,  8'sd3,   8'sd5,  8'sd0,  3'd7,1'b1,1'b0, 24'sd0,     "R2"},
        '{3'd2,   8'sd20, -8'sd5, 8'sd6,    3'd0,1'b0,1'b0, -8'sd8,  -8'sd8, -8'sd3,  3'd0,1'b0,1'b0, 24'sd0,     "R3"},
        '{3'd3,   8'sd9,   8'sd4, 8'sd0,    3'd0,1'b1,1'b0, -8'sd3,  -8'sd4,  8'sd0,  3'd0,1'b0,1'b0, 24'sd0,     "R4"},
        '{3'd4,  -8'sd6,   8'sd0, 8'sd0,    3'd1,1'b0,1'b0,  8'sd11,  8'sd0,  8'sd0,  3'd0,1'b0,1'b0, 24'sd0,     "R5"},
        '{3'd6,   8'sd4,   8'sd4, 8'sd0,    3'd0,1'b0,1'b0, -8'sd2,   8'sd9,  8'sd0,  3'd0,1'b0,1'b0, 24'sd0,     "R5"},
        '{3'd0,   8'sd12,  8'sd12,8'sd0,    3'd0,1'b0,1'b1,  8'sd6,  -8'sd7,  8'sd0,  3'd0,1'b0,1'b1, 24'sd0,     "R6"},
        '{3'd0,   8'sd2,   8'sd3, 8'sd0,    3'd0,1'b0,1'b0,  8'sd1,   8'sd1,  8'sd0,  3'd0,1'b0,1'b0, 24'sd1000,  "R7"},
        '{3'd3, -8'sd128,-8'sd128,8'sd0,    3'd0,1'b0,1'b0,  8'sd127,-8'sd128,8'sd0,  3'd0,1'b1,1'b0, 24'sd0,     "R12"},
        '{3'd1, -8'sd128,-8'sd128,8'sd0,    3'd7,1'b0,1'b1,  8'sd127, 8'sd127,8'sd0,  3'd7,1'b0,1'b0, 24'sd0,     "R12"},
        '{3'd2, -8'sd128, 8'sd127,-8'sd128, 3'd0,1'b1,1'b0,  8'sd0,   8'sd0,  8'sd0,  3'd0,1'b0,1'b0, -24'sd5000, "R7"}
    };
    localparam vec_t ZV = '0;

    int K0 [8] = '{3, -5, 7, -11, 13, -17, 19, -128};
    int K1 [8] = '{-2, 4, -6, 8, -10, 12, -14, 127};

    int nchk = 0, nfail = 0;
    bit done = 0;

    function automatic longint lane_m(int ln, int m, int a, int b, int c, int s, bit p, bit n);
        longint pre, k, v;
        pre = p ? a - b : a + b;
        k   = ln ? K1[s] : K0[s];
        case (m)
            1: v = pre * k;
            2: v = pre * c;
            3: v = pre * pre;
            4: v = a * k;
            default: v = a * b;
        endcase
        return n ? -v : v;
    endfunction

    function automatic longint model(vec_t v);
        return lane_m(0, v.m, v.a0, v.b0, v.c0, v.s0, v.p0, v.n0)
             + lane_m(1, v.m, v.a1, v.b1, v.c1, v.s1, v.p1, v.n1)
             + longint'(v.ch);
    endfunction

    task automatic drive(vec_t v, logic ld);
        mode = v.m; load = ld; chain_in = v.ch;
        a0 = v.a0; b0 = v.b0; c0 = v.c0; sel0 = v.s0; psub0 = v.p0; neg0 = v.n0;
        a1 = v.a1; b1 = v.b1; c1 = v.c1; sel1 = v.s1; psub1 = v.p1; neg1 = v.n1;
    endtask

    task automatic check(string tag, longint exp);
        logic [RW-1:0] e;
        e = exp[RW-1:0];
        nchk++;
        if (result !== e) begin
            nfail++;
            $display("FAIL %s got=%0d exp=%0d", tag, $signed(result), $signed(e));
        end
    endtask

    task automatic step(); @(posedge clk); @(negedge clk); endtask

    initial begin
        drive(ZV, 1'b1);
        #1 check("R10", 0);
        @(negedge clk); clr = 0; ce = 1;
        repeat (LAT) step();
        check("R10", 0);

        // table walk, one vector at a time (R1..R7, R12)
        for (int i = 0; i < NV; i++) begin
            drive(TV[i], 1'b1);
            repeat (LAT) step();
            check(string'(TV[i].tag), model(TV[i]));
        end

        // R8: exact latency and back-to-back streaming
        drive(ZV, 1'b1); repeat (LAT + 2) step();
        drive(TV[0], 1'b1); step();
        drive(TV[3], 1'b1); step();
        drive(TV[6], 1'b1); step();
        drive(ZV, 1'b1);
        check("R8", 0);
        step(); check("R8", model(TV[0]));
        step(); check("R8", model(TV[3]));
        step(); check("R8", model(TV[6]));
        step(); check("R8", 0);

        // R9: accumulate then reload
        drive(TV[3], 1'b1); step();
        drive(TV[4], 1'b0); step();
        drive(TV[6], 1'b0); step();
        drive(ZV, 1'b0);
        step(); check("R9", model(TV[3]));
        step(); check("R9", model(TV[3]) + model(TV[4]));
        step(); check("R9", model(TV[3]) + model(TV[4]) + model(TV[6]));
        step(); check("R9", model(TV[3]) + model(TV[4]) + model(TV[6]));
        drive(TV[0], 1'b1); repeat (LAT) step();
        check("R9", model(TV[0]));

        // R11: freeze mid-pipeline, garbage ignored, then drain
        drive(ZV, 1'b1); repeat (LAT + 1) step();
        drive(TV[1], 1'b1); step();
        drive(TV[2], 1'b1); step();
        ce = 0; drive(TV[8], 1'b0);
        repeat (3) step();
        check("R11", 0);
        ce = 1; drive(ZV, 1'b1);
        step(); check("R11", 0);
        step(); check("R11", model(TV[1]));
        step(); check("R11", model(TV[2]));
        step(); check("R11", 0);

        // R10: asynchronous clear between edges
        drive(TV[7], 1'b1); repeat (LAT) step();
        clr = 1; #0.5;
        check("R10", 0);
        @(negedge clk); clr = 0;
        step(); check("R10", 0);

        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
        $finish;
    end

    initial begin
        #100000;
        if (!done) begin
            nfail++;
            $display("FAIL watchdog got=hung exp=finish");
            $display("  TB_RESULT checks=%0d failures=%0d", nchk, nfail);
            $finish;
        end
    end
endmodule